// File: doc/BRIEF.md
# Watchdog Timer With Early-Warning Interrupt

The block is a free-running watchdog counter that software must keep restarting. A two-bit select field picks one of four timeout lengths, each a power of two in clocks. A fixed number of clocks before the timeout, the block raises an interrupt flag as an early warning. At the timeout it can raise a reset flag and request a system reset. The flag can show where software failed to restart the counter, or it can serve as a periodic time base. When the counter reaches the timeout it wraps to zero and keeps counting.

The reset-enable bit and the restart bit are guarded. The only way to change them is to write a two-byte unlock key to an access register on back-to-back cycles. That opens a short window, and the window accepts one write to the control register. Plain writes to those two bits have no effect. This keeps errant code from disabling the watchdog or feeding it by accident. The reset-flag clear bit and the timeout select field are not guarded.

Register map (`wr_addr`): 0 = config (bits 7:6 timeout select), 1 = control (bit 0 restart, bit 1 reset enable, bit 3 write-1 clears the reset flag), 2 = access (unlock key 8'hAA, then 8'h55).

Top module: `wdt_core`

## Requirements
- R1: After `rst_n` is released, `int_flag`, `rst_flag` and `sys_rst_req` are 0, reset is disabled and the select field is 0.
- R2: With select code s written to config bits 7:6, the timeout falls 2^TO_EXPs clocks after the restart edge. At the timeout the counter wraps to zero, so with no further restart the next timeout comes exactly one period later.
- R3: `int_flag` rises on the clock edge exactly PRE_CLKS edges before the edge of the timeout. It then stays set until a restart.
- R4: When `int_en` is low at the warning point, `int_flag` does not set.
- R5: At a timeout with reset enabled, `rst_flag` sets on the timeout edge. `sys_rst_req` goes high on the same edge and stays high for exactly RST_PULSE clocks.
- R6: At a timeout with reset disabled, neither `rst_flag` nor `sys_rst_req` rises.
- R7: A control write made outside an open window leaves the reset-enable bit unchanged and does not restart the counter.
- R8: Writing 8'hAA and then 8'h55 to the access register on consecutive cycles opens a window of WIN_CLKS cycles. The window accepts one control write. A key split by an idle cycle opens nothing. The window closes when the write is accepted or when the cycles run out.
- R9: An accepted restart clears the count and `int_flag`. It leaves a set `rst_flag` set.
- R10: A control write with bit 3 set clears `rst_flag`, with or without a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 config, 1 control, 2 access |
| wr_data | input | 8 | Write data |
| int_en | input | 1 | Allows the early-warning flag to set |
| int_flag | output | 1 | Early-warning interrupt flag |
| rst_flag | output | 1 | Watchdog reset flag |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
The bench builds the block with timeout exponents 10, 11, 12 and 13 and keeps the default 512-clock warning lead, 3-cycle window and 4-clock pulse. At these settings all four select codes, a counter wrap and a second consecutive timeout fit in a short run. The warning point still sits well inside even the shortest period. Each timeout is timed against the edge of the last accepted restart. This shows whether a plain, late or split-key write was truly ignored.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    REG_CFG = 2'd0,
    REG_CTL = 2'd1,
    REG_ACC = 2'd2,
    REG_NONE = 2'd3
  } wdt_reg_e;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  localparam int CTL_RESTART_BIT = 0;
  localparam int CTL_RSTEN_BIT   = 1;
  localparam int CTL_CLRFLAG_BIT = 3;
  localparam int CFG_SEL_LSB     = 6;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/wdt_timed_access.sv
module wdt_timed_access #(
  parameter int unsigned WIN_CLKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_wr,
  input  logic [7:0] acc_data,
  input  logic       consume,
  output logic       win_open
);
  import wdt_pkg::*;

  localparam int WIN_W = $clog2(WIN_CLKS + 1);

  logic             armed_q;
  logic [WIN_W-1:0] win_q;
  logic             key_done;

  assign key_done = acc_wr && armed_q && (acc_data == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      win_q   <= '0;
    end else begin
      armed_q <= acc_wr && (acc_data == KEY_FIRST);
      if (key_done)
        win_q <= WIN_W'(WIN_CLKS);
      else if (consume)
        win_q <= '0;
      else if (win_q != '0)
        win_q <= win_q - WIN_W'(1);
    end
  end

  assign win_open = (win_q != '0);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned TO_EXP0  = 17,
  parameter int unsigned TO_EXP1  = 20,
  parameter int unsigned TO_EXP2  = 23,
  parameter int unsigned TO_EXP3  = 26,
  parameter int unsigned PRE_CLKS = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       restart,
  output logic       pre_evt,
  output logic       to_evt
);
  import wdt_pkg::*;

  localparam int unsigned CNT_W = max4(TO_EXP0, TO_EXP1, TO_EXP2, TO_EXP3);
  localparam int unsigned EXP_TAB [4] = '{TO_EXP0, TO_EXP1, TO_EXP2, TO_EXP3};

  logic [CNT_W-1:0] last_v [4];
  logic [CNT_W-1:0] warn_v [4];
  logic [CNT_W-1:0] cnt_q;
  logic             to_hit;
  logic             pre_hit;

  for (genvar g = 0; g < 4; g++) begin : g_limits
    assign last_v[g] = CNT_W'((64'd1 << EXP_TAB[g]) - 64'd1);
    assign warn_v[g] = CNT_W'((64'd1 << EXP_TAB[g]) - 64'd1 - 64'(PRE_CLKS));
  end

  assign to_hit  = (cnt_q >= last_v[sel]);
  assign pre_hit = (cnt_q == warn_v[sel]);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (restart || to_hit)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + CNT_W'(1);
  end

  assign to_evt  = to_hit  && !restart;
  assign pre_evt = pre_hit && !restart;

endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int unsigned RST_PULSE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic req
);
  localparam int PW = $clog2(RST_PULSE + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      left_q <= '0;
    else if (fire)
      left_q <= PW'(RST_PULSE);
    else if (left_q != '0)
      left_q <= left_q - PW'(1);
  end

  assign req = (left_q != '0);

endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int unsigned TO_EXP0   = 17,
  parameter int unsigned TO_EXP1   = 20,
  parameter int unsigned TO_EXP2   = 23,
  parameter int unsigned TO_EXP3   = 26,
  parameter int unsigned PRE_CLKS  = 512,
  parameter int unsigned WIN_CLKS  = 3,
  parameter int unsigned RST_PULSE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       int_en,
  output logic       int_flag,
  output logic       rst_flag,
  output logic       sys_rst_req
);
  import wdt_pkg::*;

  logic [1:0] sel_q;
  logic       rst_en_q;
  logic       int_q;
  logic       rflag_q;
  logic       cfg_wr, ctl_wr, acc_wr;
  logic       win_open, accept, restart, ctl_clr;
  logic       pre_evt, to_evt, fire;

  assign cfg_wr  = wr_en && (wdt_reg_e'(wr_addr) == REG_CFG);
  assign ctl_wr  = wr_en && (wdt_reg_e'(wr_addr) == REG_CTL);
  assign acc_wr  = wr_en && (wdt_reg_e'(wr_addr) == REG_ACC);
  assign accept  = ctl_wr && win_open;
  assign restart = accept && wr_data[CTL_RESTART_BIT];
  assign ctl_clr = ctl_wr && wr_data[CTL_CLRFLAG_BIT];

  wdt_timed_access #(.WIN_CLKS(WIN_CLKS)) u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_wr   (acc_wr),
    .acc_data (wr_data),
    .consume  (accept),
    .win_open (win_open)
  );

  wdt_counter #(
    .TO_EXP0 (TO_EXP0), .TO_EXP1 (TO_EXP1),
    .TO_EXP2 (TO_EXP2), .TO_EXP3 (TO_EXP3),
    .PRE_CLKS(PRE_CLKS)
  ) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel_q),
    .restart (restart),
    .pre_evt (pre_evt),
    .to_evt  (to_evt)
  );

  assign fire = to_evt && rst_en_q;

  wdt_rst_pulse #(.RST_PULSE(RST_PULSE)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .req   (sys_rst_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= 2'd0;
      rst_en_q <= 1'b0;
      int_q    <= 1'b0;
      rflag_q  <= 1'b0;
    end else begin
      if (cfg_wr)
        sel_q <= wr_data[CFG_SEL_LSB +: 2];
      if (accept)
        rst_en_q <= wr_data[CTL_RSTEN_BIT];
      if (restart)
        int_q <= 1'b0;
      else if (pre_evt && int_en)
        int_q <= 1'b1;
      if (fire)
        rflag_q <= 1'b1;
      else if (ctl_clr)
        rflag_q <= 1'b0;
    end
  end

  assign int_flag = int_q;
  assign rst_flag = rflag_q;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned RST_PULSE = 4
) (
  input logic clk,
  input logic rst_n,
  input logic ctl_wr,
  input logic ctl_clr,
  input logic win_open,
  input logic accept,
  input logic restart,
  input logic rst_en_q,
  input logic int_en,
  input logic int_flag,
  input logic rst_flag,
  input logic sys_rst_req
);
  localparam int RW = $clog2(RST_PULSE + 2);

  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)
      run_len <= '0;
    else if (sys_rst_req)
      run_len <= run_len + RW'(1);
    else
      run_len <= '0;
  end

  assert_pulse_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_req) |-> (run_len == RW'(RST_PULSE)));

  assert_flag_with_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> rst_flag);

  assert_req_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> $past(rst_en_q));

  assert_plain_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !win_open) |=> $stable(rst_en_q));

  assert_window_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !win_open);

  assert_restart_int_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !int_flag);

  assert_restart_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && rst_flag && !ctl_clr) |=> rst_flag);

  assert_int_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_flag) |-> $past(int_en));

endmodule

bind wdt_core wdt_checker #(.RST_PULSE(RST_PULSE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr     (ctl_wr),
  .ctl_clr    (ctl_clr),
  .win_open   (win_open),
  .accept     (accept),
  .restart    (restart),
  .rst_en_q   (rst_en_q),
  .int_en     (int_en),
  .int_flag   (int_flag),
  .rst_flag   (rst_flag),
  .sys_rst_req(sys_rst_req)
);

// File: tb/sim_wdt_core.sv
module sim_wdt_core;
  localparam int CLK_PERIOD = 10;
  localparam int PRE = 512;
  localparam int EXPS [4] = '{10, 11, 12, 13};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       int_en = 1'b0;
  logic       int_flag, rst_flag, sys_rst_req;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int t_rs = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_core #(
    .TO_EXP0(EXPS[0]), .TO_EXP1(EXPS[1]), .TO_EXP2(EXPS[2]), .TO_EXP3(EXPS[3]),
    .PRE_CLKS(PRE), .WIN_CLKS(3), .RST_PULSE(4)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .int_en(int_en), .int_flag(int_flag), .rst_flag(rst_flag), .sys_rst_req(sys_rst_req)
  );

  function automatic int period(input int s);
    return 1 << EXPS[s];
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock_ctl(input logic [7:0] d);
    wr(2'd2, 8'hAA);
    wr(2'd2, 8'h55);
    wr(2'd1, d);
    if (d[0]) t_rs = cyc;
  endtask

  // waits for rst_flag, checks the delay from the last restart/wrap point
  task automatic wait_flag(input string req, input int exp);
    int n = 0;
    while (!rst_flag && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(req, cyc - t_rs, exp);
    t_rs = cyc;
    wr(2'd1, 8'h08);
  endtask

  initial begin
    int seen;
    void'($urandom(32'd5150));
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 int_flag", int_flag, 0);
    chk("R1 rst_flag", rst_flag, 0);
    chk("R1 sys_rst_req", sys_rst_req, 0);

    // R4 / R6: interrupt disabled, reset disabled
    wr(2'd0, 8'h00);
    unlock_ctl(8'h01);
    seen = 0;
    for (int i = 0; i < period(0) + 10; i++) begin
      @(negedge clk);
      if (sys_rst_req || rst_flag) seen = 1;
    end
    chk("R4 int_flag stays low", int_flag, 0);
    chk("R6 no reset without enable", seen, 0);

    // R3 / R5: warning point and reset pulse
    int_en = 1'b1;
    unlock_ctl(8'h03);
    idle(period(0) - PRE - 1);
    chk("R3 int_flag before warning", int_flag, 0);
    idle(1);
    chk("R3 int_flag at warning", int_flag, 1);
    idle(PRE - 1);
    chk("R5 rst_flag before timeout", rst_flag, 0);
    idle(1);
    chk("R5 rst_flag at timeout", rst_flag, 1);
    chk("R5 req first cycle", sys_rst_req, 1);
    idle(3);
    chk("R5 req fourth cycle", sys_rst_req, 1);
    idle(1);
    chk("R5 req ends", sys_rst_req, 0);

    // R9 / R10
    unlock_ctl(8'h03);
    chk("R9 restart clears int_flag", int_flag, 0);
    chk("R9 restart keeps rst_flag", rst_flag, 1);
    wr(2'd1, 8'h08);
    chk("R10 clear rst_flag", rst_flag, 0);

    // R2: wrap and second period
    wait_flag("R2 first timeout", period(0));
    wait_flag("R2 wrap period", period(0));

    // R2: other select codes
    for (int s = 1; s < 4; s++) begin
      wr(2'd0, 8'(s << 6));
      unlock_ctl(8'h03);
      wait_flag($sformatf("R2 select %0d", s), period(s));
    end
    wr(2'd0, 8'h00);
    unlock_ctl(8'h03);
    wait_flag("R2 back to select 0", period(0));

    // R7: random plain control writes are ignored
    for (int k = 0; k < 6; k++) begin
      idle($urandom_range(5, 90));
      wr(2'd1, 8'($urandom) & 8'hF4);
    end
    wait_flag("R7 plain writes ignored", period(0));

    // R8: split key opens nothing
    wr(2'd2, 8'hAA); idle(1); wr(2'd2, 8'h55); wr(2'd1, 8'h01);
    wait_flag("R8 split key", period(0));
    // R8: late write after window expiry
    wr(2'd2, 8'hAA); wr(2'd2, 8'h55); idle(3); wr(2'd1, 8'h01);
    wait_flag("R8 window expired", period(0));
    // R8: write in last window cycle accepted
    wr(2'd2, 8'hAA); wr(2'd2, 8'h55); idle(2); wr(2'd1, 8'h03); t_rs = cyc;
    wait_flag("R8 last window cycle", period(0));
    // R8: only one write per window
    wr(2'd2, 8'hAA); wr(2'd2, 8'h55); wr(2'd1, 8'h02); wr(2'd1, 8'h03);
    wait_flag("R8 one write per window", period(0));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule